// File: doc/BRIEF.md
# EEPROM erase/write cycle sequencer

This block carries out the internal programming cycle of a small page-organised EEPROM once the bus front-end has collected a complete write and seen the end of the transfer. The front-end hands over one commit request. The request holds a page number, a byte-valid mask and up to eight data bytes. The sequencer then runs a timed cycle that changes a behavioural storage array. While the cycle runs, the sequencer raises a busy flag, and the front-end uses that flag to refuse new accesses. The bus itself stays free for other traffic while the cycle runs.

There are two modes. Page mode runs a single block-erase phase, which sets every masked byte of the page to all ones. It then runs eight program slots of equal length, one per byte position in ascending order, so the total time is the same whatever the mask holds. Byte mode gives each masked byte its own slot, which combines erase and program. Unmasked positions take no time in byte mode. Each phase length is a parameter counted in clock ticks. The defaults match millisecond timing at a 250 MHz clock, and a bench can set them much shorter. A read port shows the array contents at any time.

The commit input uses a valid/ready handshake. `cmt_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `cmt_valid` and `cmt_ready` are high. The sender must hold its request until it is taken. A request shown while ready is low is not taken and has no effect.

Top module: `eews_seq`

## Requirements
- R1: After reset, `busy`, `er_stb` and `wr_stb` are low, `cmt_ready` is high, and every array byte reads 0x00.
- R2: `cmt_ready` is high exactly when `busy` is low. A request taken at clock edge A makes `busy` read high in the cycle that starts at A.
- R3: In page mode (`cmt_page_mode`=1), `busy` stays high for ERASE_TICKS + 8*PROG_TICKS + 1 cycles counted from the accepting edge. This holds for any mask, including zero.
- R4: In page mode, `er_stb` pulses in the last cycle of the ERASE_TICKS-long erase phase. From the next cycle, each byte `page*8+k` whose mask bit k is set reads 0xFF.
- R5: In page mode, slot k (k=0..7) ends ERASE_TICKS + (k+1)*PROG_TICKS cycles after acceptance. If mask bit k is set, `wr_stb` is high in the last cycle of that slot, with `wr_data` equal to `cmt_data[8k+7:8k]`. That byte is stored at the end of the cycle. `er_stb` and `wr_stb` are never high together.
- R6: In byte mode (`cmt_page_mode`=0), each of the n masked bytes gets one slot of BYTE_TICKS cycles, in ascending k order. The write happens in the last cycle of its slot. `busy` lasts n*BYTE_TICKS + 1 cycles, which is 1 cycle when the mask is zero.
- R7: A request presented while `busy` is high is not taken. It changes neither the array nor the timing of the running cycle.
- R8: Bytes whose mask bit is clear are never erased or written, and they keep their previous value.
- R9: Every write address is `page*8+k`. The stored page, mask and data stay constant from acceptance until `busy` falls, and this holds for the last page too.
- R10: `busy` falls one cycle after the last slot ends, and `cmt_ready` returns high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmt_valid | input | 1 | Commit request present |
| cmt_ready | output | 1 | Sequencer idle, request can be taken |
| cmt_page_mode | input | 1 | 1 = page mode (erase then eight slots), 0 = byte mode |
| cmt_page | input | AW-3 (5) | Page number, upper address bits |
| cmt_mask | input | 8 | Byte-valid mask, bit k selects byte k |
| cmt_data | input | 64 | Data bytes, byte k at bits [8k+7:8k] |
| busy | output | 1 | Erase/write cycle in progress |
| er_stb | output | 1 | Block-erase strobe |
| wr_stb | output | 1 | Per-byte program strobe |
| wr_addr | output | AW (8) | Program address |
| wr_data | output | 8 | Program data |
| rd_addr | input | AW (8) | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
Some properties are checked by assertions on every cycle. An accepted request always raises busy, and busy never rises without one. No request is taken while busy. The two strobes never overlap, and both stay inside a busy window. Only page mode erases. The latched page and mask stay stable through the cycle. Other behaviour depends on exact cycle counts and on what the array holds, so only the bench scenarios can show it. This covers when each slot ends, the total busy length in both modes and with empty masks, the all-ones value after erase, unmasked bytes being preserved, the final data, and a refused request leaving no trace.

// File: rtl/eews_pkg.sv
package eews_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/eews_timer.sv
module eews_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          tc
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tc = (cnt_q == '0);

endmodule

// File: rtl/eews_slot_sel.sv
module eews_slot_sel #(
  parameter int unsigned NB = 8,
  parameter int unsigned IW = 3
) (
  input  logic [NB-1:0] mask,
  input  logic [IW-1:0] cur,
  input  logic          from_start,
  output logic [IW-1:0] nxt,
  output logic          found
);

  logic [NB-1:0] elig;

  for (genvar i = 0; i < NB; i++) begin : g_elig
    assign elig[i] = mask[i] && (from_start || (IW'(i) > cur));
  end

  always_comb begin
    found = 1'b0;
    nxt   = '0;
    for (int k = NB - 1; k >= 0; k--) begin
      if (elig[k]) begin
        found = 1'b1;
        nxt   = IW'(k);
      end
    end
  end

endmodule

// File: rtl/eews_array.sv
module eews_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned NB = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  er_stb,
  input  logic [AW-$clog2(NB)-1:0] er_page,
  input  logic [NB-1:0]         er_mask,
  input  logic                  wr_stb,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = $clog2(NB);
  localparam int unsigned GW    = AW - PW;

  logic [DEPTH*8-1:0] flat;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam int unsigned PG = w / NB;
    localparam int unsigned BI = w % NB;
    logic [7:0] q;
    logic       er_hit;
    logic       wr_hit;

    assign er_hit = er_stb && (er_page == GW'(PG)) && er_mask[BI];
    assign wr_hit = wr_stb && (wr_addr == AW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 8'h00;
      end else if (wr_hit) begin
        q <= wr_data;
      end else if (er_hit) begin
        q <= 8'hFF;
      end
    end

    assign flat[w*8 +: 8] = q;
  end

  assign rd_data = flat[{rd_addr, 3'b000} +: 8];

endmodule

// File: rtl/eews_seq.sv
module eews_seq
  import eews_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned NB          = 8,
  parameter int unsigned ERASE_TICKS = 875000,
  parameter int unsigned PROG_TICKS  = 875000,
  parameter int unsigned BYTE_TICKS  = 2500000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmt_valid,
  output logic                    cmt_ready,
  input  logic                    cmt_page_mode,
  input  logic [AW-$clog2(NB)-1:0] cmt_page,
  input  logic [NB-1:0]           cmt_mask,
  input  logic [NB*8-1:0]         cmt_data,
  output logic                    busy,
  output logic                    er_stb,
  output logic                    wr_stb,
  output logic [AW-1:0]           wr_addr,
  output logic [7:0]              wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [7:0]              rd_data
);

  localparam int unsigned PW   = $clog2(NB);
  localparam int unsigned GW   = AW - PW;
  localparam int unsigned IW   = PW;
  localparam int unsigned MAXA = (ERASE_TICKS > PROG_TICKS) ? ERASE_TICKS : PROG_TICKS;
  localparam int unsigned MAXT = (MAXA > BYTE_TICKS) ? MAXA : BYTE_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] E_LD = CW'(ERASE_TICKS - 1);
  localparam logic [CW-1:0] P_LD = CW'(PROG_TICKS - 1);
  localparam logic [CW-1:0] B_LD = CW'(BYTE_TICKS - 1);
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  phase_e          phase_q, phase_d;
  logic            pmode_q;
  logic [GW-1:0]   page_q;
  logic [NB-1:0]   mask_q;
  logic [NB*8-1:0] data_q;
  logic [IW-1:0]   idx_q, idx_d;

  logic            accept;
  logic            tc;
  logic            t_load;
  logic [CW-1:0]   t_val;
  logic            slot_end;
  logic [NB-1:0]   sel_mask;
  logic            sel_start;
  logic [IW-1:0]   sel_nxt;
  logic            sel_found;

  assign cmt_ready = (phase_q == PH_IDLE);
  assign busy      = (phase_q != PH_IDLE);
  assign accept    = cmt_valid && cmt_ready;

  // slot selection for byte mode: from the incoming mask when idle,
  // from the latched mask above the current slot otherwise
  assign sel_start = (phase_q == PH_IDLE);
  assign sel_mask  = sel_start ? cmt_mask : mask_q;

  eews_slot_sel #(.NB(NB), .IW(IW)) u_sel (
    .mask       (sel_mask),
    .cur        (idx_q),
    .from_start (sel_start),
    .nxt        (sel_nxt),
    .found      (sel_found)
  );

  eews_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .tc       (tc)
  );

  assign er_stb   = (phase_q == PH_ERASE) && tc;
  assign slot_end = (phase_q == PH_PROG) && tc;
  assign wr_stb   = slot_end && mask_q[idx_q];
  assign wr_addr  = {page_q, idx_q};
  assign wr_data  = data_q[{idx_q, 3'b000} +: 8];

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          if (cmt_page_mode) begin
            phase_d = PH_ERASE;
            t_load  = 1'b1;
            t_val   = E_LD;
          end else if (sel_found) begin
            phase_d = PH_PROG;
            idx_d   = sel_nxt;
            t_load  = 1'b1;
            t_val   = B_LD;
          end else begin
            phase_d = PH_DONE;
          end
        end
      end
      PH_ERASE: begin
        if (tc) begin
          phase_d = PH_PROG;
          idx_d   = '0;
          t_load  = 1'b1;
          t_val   = P_LD;
        end
      end
      PH_PROG: begin
        if (tc) begin
          if (pmode_q) begin
            if (idx_q == LAST) begin
              phase_d = PH_DONE;
            end else begin
              idx_d  = idx_q + 1'b1;
              t_load = 1'b1;
              t_val  = P_LD;
            end
          end else if (sel_found) begin
            idx_d  = sel_nxt;
            t_load = 1'b1;
            t_val  = B_LD;
          end else begin
            phase_d = PH_DONE;
          end
        end
      end
      PH_DONE: begin
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmode_q <= 1'b0;
      page_q  <= '0;
      mask_q  <= '0;
      data_q  <= '0;
    end else if (accept) begin
      pmode_q <= cmt_page_mode;
      page_q  <= cmt_page;
      mask_q  <= cmt_mask;
      data_q  <= cmt_data;
    end
  end

  eews_array #(.AW(AW), .NB(NB)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .er_stb  (er_stb),
    .er_page (page_q),
    .er_mask (mask_q),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/eews_chk.sv
module eews_chk #(
  parameter int unsigned NB = 8,
  parameter int unsigned GW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmt_valid,
  input logic          cmt_ready,
  input logic          busy,
  input logic          er_stb,
  input logic          wr_stb,
  input logic          pmode_q,
  input logic [GW-1:0] page_q,
  input logic [NB-1:0] mask_q
);

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_ready) |=> busy); // R2

  AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmt_valid && cmt_ready)); // R2

  AST_NO_ACCEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmt_ready); // R7

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({er_stb, wr_stb})); // R5

  AST_WR_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || er_stb) |-> busy); // R5

  AST_ERASE_PAGE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    er_stb |-> pmode_q); // R4

  AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(page_q) && $stable(mask_q))); // R9

endmodule

bind eews_seq eews_chk #(.NB(NB), .GW(GW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmt_valid (cmt_valid),
  .cmt_ready (cmt_ready),
  .busy      (busy),
  .er_stb    (er_stb),
  .wr_stb    (wr_stb),
  .pmode_q   (pmode_q),
  .page_q    (page_q),
  .mask_q    (mask_q)
);

// File: tb/tb_eews_seq.sv
`timescale 1ns/1ps
module tb_eews_seq;

  localparam int AW = 8;
  localparam int NB = 8;
  localparam int GW = 5;
  localparam int E  = 5;
  localparam int P  = 3;
  localparam int B  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmt_valid = 1'b0;
  logic          cmt_ready;
  logic          cmt_page_mode = 1'b0;
  logic [GW-1:0] cmt_page = '0;
  logic [NB-1:0] cmt_mask = '0;
  logic [63:0]   cmt_data = '0;
  logic          busy, er_stb, wr_stb;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;

  always #2 clk = ~clk;

  eews_seq #(.AW(AW), .NB(NB), .ERASE_TICKS(E), .PROG_TICKS(P), .BYTE_TICKS(B)) dut (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_ready(cmt_ready),
    .cmt_page_mode(cmt_page_mode), .cmt_page(cmt_page), .cmt_mask(cmt_mask),
    .cmt_data(cmt_data), .busy(busy), .er_stb(er_stb), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct { int t; logic [7:0] a; logic [7:0] d; } wr_item_t;
  wr_item_t   wr_q[$];
  int         er_q[$];
  logic [7:0] model [0:255];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected strobes and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (wr_q.size() == 0) begin
          check(1'b0, "R8 unexpected write", int'(wr_addr), 0);
        end else begin
          wr_item_t it;
          it = wr_q.pop_front();
          check(cyc == it.t, "R5 write cycle", cyc, it.t);
          check(wr_addr == it.a, "R9 write address", int'(wr_addr), int'(it.a));
          check(wr_data == it.d, "R5 write data", int'(wr_data), int'(it.d));
        end
      end
      if (er_stb) begin
        if (er_q.size() == 0) begin
          check(1'b0, "R4 unexpected erase", cyc, 0);
        end else begin
          int et;
          et = er_q.pop_front();
          check(cyc == et, "R4 erase cycle", cyc, et);
        end
      end
    end
  end

  function automatic logic [63:0] mkdata(input logic [7:0] seed);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = seed + 8'(k * 17);
    return v;
  endfunction

  // driver: presents one request, pushes expected strobes, returns accept cycle
  task automatic commit(input bit pm, input logic [GW-1:0] pg, input logic [7:0] m,
                        input logic [63:0] d, output int acc, output int dur);
    int j;
    @(negedge clk);
    cmt_page_mode = pm; cmt_page = pg; cmt_mask = m; cmt_data = d; cmt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    cmt_valid = 1'b0;
    j = 0;
    if (pm) begin
      er_q.push_back(acc + E - 1);
      for (int k = 0; k < 8; k++)
        if (m[k]) wr_q.push_back('{acc + E + (k + 1) * P - 1, 8'(int'(pg) * 8 + k), d[k*8 +: 8]});
      dur = E + 8 * P;
    end else begin
      for (int k = 0; k < 8; k++)
        if (m[k]) begin
          wr_q.push_back('{acc + (j + 1) * B - 1, 8'(int'(pg) * 8 + k), d[k*8 +: 8]});
          j++;
        end
      dur = j * B;
    end
    for (int k = 0; k < 8; k++)
      if (m[k]) model[int'(pg) * 8 + k] = d[k*8 +: 8];
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run(input int acc, input int dur, input string req);
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    while (busy) @(negedge clk);
    check(cyc == acc + dur + 1, req, cyc, acc + dur + 1);
    check(cmt_ready == 1'b1, "R10 ready back with busy low", cmt_ready, 1);
    check(wr_q.size() == 0 && er_q.size() == 0, "R5 all strobes seen", wr_q.size(), 0);
  endtask

  task automatic readback(input int a, input logic [7:0] exp, input string req);
    rd_addr = 8'(a);
    #1;
    check(rd_data == exp, req, int'(rd_data), int'(exp));
  endtask

  task automatic read_page(input int pg, input string req);
    for (int k = 0; k < 8; k++) readback(pg * 8 + k, model[pg * 8 + k], req);
  endtask

  initial begin
    int acc, dur;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy low", busy, 0);
    check(cmt_ready == 1'b1, "R1 ready high", cmt_ready, 1);
    check(wr_stb == 1'b0 && er_stb == 1'b0, "R1 strobes low", wr_stb, 0);
    readback(0, 8'h00, "R1 array cleared");
    readback(255, 8'h00, "R1 array cleared");

    // page mode, full mask; erase visible before slot 0 ends
    commit(1'b1, 5'd3, 8'hFF, mkdata(8'h11), acc, dur);
    wait_cyc(acc + E);
    readback(24, 8'hFF, "R4 erased to ones");
    readback(31, 8'hFF, "R4 erased to ones");
    finish_run(acc, dur, "R3 page busy length");
    read_page(3, "R5 page data stored");

    // page mode, partial mask: unmasked bytes survive erase and program
    commit(1'b1, 5'd3, 8'hA5, mkdata(8'h40), acc, dur);
    wait_cyc(acc + E);
    readback(24, 8'hFF, "R4 masked byte erased");
    readback(25, model[25], "R8 unmasked byte kept");
    finish_run(acc, dur, "R3 page busy length partial");
    read_page(3, "R8 partial mask result");

    // request during busy is refused
    commit(1'b1, 5'd5, 8'hFF, mkdata(8'h77), acc, dur);
    wait_cyc(acc + 3);
    check(cmt_ready == 1'b0, "R7 ready low while busy", cmt_ready, 0);
    cmt_page_mode = 1'b1; cmt_page = 5'd6; cmt_mask = 8'hFF; cmt_data = mkdata(8'h99);
    cmt_valid = 1'b1;
    @(negedge clk);
    cmt_valid = 1'b0;
    finish_run(acc, dur, "R7 timing unaffected");
    read_page(6, "R7 refused request left no data");
    read_page(5, "R5 page 5 data");

    // byte mode, two bytes
    commit(1'b0, 5'd10, 8'h12, mkdata(8'h05), acc, dur);
    finish_run(acc, dur, "R6 byte busy length");
    read_page(10, "R6 byte mode data");

    // byte mode, empty mask
    commit(1'b0, 5'd11, 8'h00, mkdata(8'h33), acc, dur);
    finish_run(acc, dur, "R6 empty byte mode one cycle");

    // page mode, empty mask: full time, no change
    commit(1'b1, 5'd3, 8'h00, mkdata(8'hEE), acc, dur);
    finish_run(acc, dur, "R3 empty page mode full length");
    read_page(3, "R8 empty mask leaves page");

    // last page boundary
    commit(1'b1, 5'd31, 8'h81, mkdata(8'hC0), acc, dur);
    finish_run(acc, dur, "R10 last page busy length");
    read_page(31, "R9 last page data");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule